// File: doc/BRIEF.md
# Low Pin Count single-byte read target

This block is the peripheral side of a Low Pin Count bus. It answers one-byte reads from memory or register space. It watches the active-low frame strobe and the four multiplexed address/data lines, and it accepts a cycle only when three things hold: a zero start code is seen while the strobe is low, the next nibble is a legal read type, and the 32-bit address names this device. For an accepted cycle it pulses a read request to a backing store. It then takes the lines and plays back a fixed reply: turnaround, two wait syncs, a ready sync, the byte as two nibbles with the low nibble first, and a closing turnaround.

The backing store sits outside the block. It sees a one-clock request together with the low address bits and a space flag. It must present the byte within three clocks of the request, so a store with one clock of latency fits easily. A frame strobe that goes low at any point ends the current cycle at once. That same edge is then checked as a possible new start.

Top module: `lpc_rd_target`

## Requirements
- R1: While reset is asserted, and on the first clock after it is released, `lad_oe_o` is 0, `lad_o` is 1111b and `rd_req_o` is 0.
- R2: A cycle opens only on a rising edge where `frame_ni` is 0 and `lad_i` is 0000b. Any other nibble with the strobe low leaves the block idle, and it never drives the bus for that cycle.
- R3: The nibble after the start is the cycle type. Bits 3:2 must be 01b and bit 1 must be 0 (a read), while bit 0 has no effect. Any other value drops the cycle without driving or requesting.
- R4: The address is taken over the next eight clocks, most significant nibble first. During the request clock, `rd_addr_o` holds address bits 18:0 and `rd_mem_o` holds address bit 22 (1 = memory space, 0 = register space).
- R5: A cycle is answered only if address bits 31:23 are all 1 and bits 21:19 equal `dev_id_i`. Otherwise the block returns to idle with no request and no drive.
- R6: For an answered cycle, `rd_req_o` is high for exactly one clock: cycle clock 11, the clock after the last address nibble.
- R7: Counting the start nibble as cycle clock 1, the block drives the following nibbles, with `lad_oe_o` high from clock 12 to clock 18: 1111b at clock 12, 0101b at clocks 13 and 14, 0000b at clock 15, data bits 3:0 at clock 16, data bits 7:4 at clock 17, and 1111b at clock 18. At clock 19 `lad_oe_o` is 0, and whenever it is 0, `lad_o` reads 1111b.
- R8: If `frame_ni` is low on any rising edge, the current cycle is abandoned and `lad_oe_o` is 0 in the following clock. If `lad_i` is 0000b on that edge, a new cycle starts from it.
- R9: The byte returned is `rd_data_i` as sampled on the edge that ends clock 15. The store may therefore answer any time up to that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_ni | input | 1 | Frame strobe, active low |
| lad_i | input | 4 | Address/data lines as seen from the bus |
| dev_id_i | input | ID_W | Device select compared with address bits 21:19 |
| rd_data_i | input | 8 | Byte from the backing store |
| lad_o | output | 4 | Nibble driven onto the lines |
| lad_oe_o | output | 1 | Line drive enable |
| rd_req_o | output | 1 | One-clock read request to the store |
| rd_addr_o | output | RD_AW | Address bits RD_AW-1:0 for the store |
| rd_mem_o | output | 1 | Space select, 1 = memory, 0 = register |

## Verification
Valid reads are run over many low-address values, in both spaces, with type bit 0 set and cleared. Since each returned byte is a different arithmetic function of its address, a nibble-order or capture-timing error changes the value seen. All sixteen cycle-type codes and all fifteen nonzero start codes are tried, which separates the type-bit decode from the start-code decode. Each of the nine top address bits is cleared in turn, and every device ID is tried. Aborts are placed in the address, turnaround, sync and data phases, plus one abort that restarts a new cycle at once, to test R8.

// File: rtl/lpc_rd_pkg.sv
package lpc_rd_pkg;
  localparam int NIB_W     = 4;
  localparam int ADDR_W    = 32;
  localparam int ADDR_NIBS = ADDR_W / NIB_W;
  localparam int SHIFT_W   = ADDR_W - NIB_W;
  localparam int ID_LSB    = 19;
  localparam int SPACE_BIT = 22;
  localparam int TOP_LSB   = 23;

  localparam logic [NIB_W-1:0] NIB_START = 4'h0;
  localparam logic [NIB_W-1:0] NIB_TAR   = 4'hF;
  localparam logic [NIB_W-1:0] NIB_WAIT  = 4'h5;
  localparam logic [NIB_W-1:0] NIB_READY = 4'h0;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_TYPE,
    ST_ADDR,
    ST_TAR_H,   // host turnaround, request to store
    ST_TAR_T,   // target takes lines
    ST_WAIT,
    ST_READY,
    ST_DLO,
    ST_DHI,
    ST_TAR_E
  } st_e;
endpackage

// File: rtl/lpc_rd_addr.sv
module lpc_rd_addr
  import lpc_rd_pkg::*;
#(
  parameter int ID_W  = 3,
  parameter int RD_AW = 19
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             shift_i,
  input  logic [NIB_W-1:0] lad_i,
  input  logic [ID_W-1:0]  dev_id_i,
  output logic             hit_o,
  output logic [RD_AW-1:0] rd_addr_o,
  output logic             rd_mem_o
);
  localparam int ID_MSB = ID_LSB + ID_W - 1;

  // Top nibble falls out of the window; the full word exists only as addr_nx.
  logic [SHIFT_W-1:0] addr_q;
  logic [ADDR_W-1:0]  addr_nx;

  assign addr_nx = {addr_q, lad_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      addr_q <= '0;
    else if (shift_i) addr_q <= addr_nx[SHIFT_W-1:0];
  end

  assign hit_o     = (&addr_nx[ADDR_W-1:TOP_LSB]) &&
                     (addr_nx[ID_MSB:ID_LSB] == dev_id_i);
  assign rd_addr_o = addr_q[RD_AW-1:0];
  assign rd_mem_o  = addr_q[SPACE_BIT];
endmodule

// File: rtl/lpc_rd_fsm.sv
module lpc_rd_fsm
  import lpc_rd_pkg::*;
#(
  parameter int WAIT_CYC = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             frame_ni,
  input  logic [NIB_W-1:0] lad_i,
  input  logic             hit_i,
  input  logic [7:0]       rd_data_i,
  output st_e              state_o,
  output logic             shift_o,
  output logic [7:0]       byte_o
);
  localparam int CNT_MAX = (ADDR_NIBS > WAIT_CYC) ? ADDR_NIBS : WAIT_CYC;
  localparam int CNT_W   = (CNT_MAX > 1) ? $clog2(CNT_MAX) : 1;
  localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(ADDR_NIBS - 1);
  localparam logic [CNT_W-1:0] WAIT_LAST = CNT_W'(WAIT_CYC - 1);

  st_e              state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [7:0]       byte_q;
  logic             type_ok;

  assign type_ok = (lad_i[3:2] == 2'b01) && !lad_i[1];

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    shift_o = 1'b0;
    if (!frame_ni) begin
      // strobe low wins everywhere: abort and re-sample for a start
      state_d = (lad_i == NIB_START) ? ST_TYPE : ST_IDLE;
    end else begin
      case (state_q)
        ST_IDLE: state_d = ST_IDLE;
        ST_TYPE: begin
          state_d = type_ok ? ST_ADDR : ST_IDLE;
          cnt_d   = '0;
        end
        ST_ADDR: begin
          shift_o = 1'b1;
          if (cnt_q == ADDR_LAST) state_d = hit_i ? ST_TAR_H : ST_IDLE;
          else                    cnt_d   = cnt_q + CNT_W'(1);
        end
        ST_TAR_H: state_d = ST_TAR_T;
        ST_TAR_T: begin
          state_d = ST_WAIT;
          cnt_d   = '0;
        end
        ST_WAIT: begin
          if (cnt_q == WAIT_LAST) state_d = ST_READY;
          else                    cnt_d   = cnt_q + CNT_W'(1);
        end
        ST_READY: state_d = ST_DLO;
        ST_DLO:   state_d = ST_DHI;
        ST_DHI:   state_d = ST_TAR_E;
        ST_TAR_E: state_d = ST_IDLE;
        default:  state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  // store has until the end of the ready sync
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  byte_q <= '0;
    else if (state_q == ST_READY) byte_q <= rd_data_i;
  end

  assign state_o = state_q;
  assign byte_o  = byte_q;
endmodule

// File: rtl/lpc_rd_drv.sv
module lpc_rd_drv
  import lpc_rd_pkg::*;
(
  input  st_e              state_i,
  input  logic [7:0]       byte_i,
  output logic [NIB_W-1:0] lad_o,
  output logic             oe_o,
  output logic             req_o
);
  always_comb begin
    lad_o = NIB_TAR;
    oe_o  = 1'b0;
    req_o = 1'b0;
    case (state_i)
      ST_TAR_H: req_o = 1'b1;
      ST_TAR_T: oe_o  = 1'b1;
      ST_WAIT: begin
        oe_o  = 1'b1;
        lad_o = NIB_WAIT;
      end
      ST_READY: begin
        oe_o  = 1'b1;
        lad_o = NIB_READY;
      end
      ST_DLO: begin
        oe_o  = 1'b1;
        lad_o = byte_i[3:0];
      end
      ST_DHI: begin
        oe_o  = 1'b1;
        lad_o = byte_i[7:4];
      end
      ST_TAR_E: oe_o = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/lpc_rd_target.sv
module lpc_rd_target
  import lpc_rd_pkg::*;
#(
  parameter int ID_W     = 3,
  parameter int RD_AW    = 19,
  parameter int WAIT_CYC = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             frame_ni,
  input  logic [3:0]       lad_i,
  input  logic [ID_W-1:0]  dev_id_i,
  input  logic [7:0]       rd_data_i,
  output logic [3:0]       lad_o,
  output logic             lad_oe_o,
  output logic             rd_req_o,
  output logic [RD_AW-1:0] rd_addr_o,
  output logic             rd_mem_o
);
  st_e        state;
  logic       shift;
  logic       hit;
  logic [7:0] byte_q;

  lpc_rd_addr #(
    .ID_W  (ID_W),
    .RD_AW (RD_AW)
  ) u_addr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .shift_i   (shift),
    .lad_i     (lad_i),
    .dev_id_i  (dev_id_i),
    .hit_o     (hit),
    .rd_addr_o (rd_addr_o),
    .rd_mem_o  (rd_mem_o)
  );

  lpc_rd_fsm #(
    .WAIT_CYC (WAIT_CYC)
  ) u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .frame_ni  (frame_ni),
    .lad_i     (lad_i),
    .hit_i     (hit),
    .rd_data_i (rd_data_i),
    .state_o   (state),
    .shift_o   (shift),
    .byte_o    (byte_q)
  );

  lpc_rd_drv u_drv (
    .state_i (state),
    .byte_i  (byte_q),
    .lad_o   (lad_o),
    .oe_o    (lad_oe_o),
    .req_o   (rd_req_o)
  );
endmodule

// File: rtl/lpc_rd_target_chk.sv
module lpc_rd_target_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       frame_ni,
  input logic [3:0] lad_o,
  input logic       lad_oe_o,
  input logic       rd_req_o
);
  p_reset_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (!lad_oe_o && lad_o == 4'hF && !rd_req_o));

  p_no_drive_without_req_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lad_oe_o) |-> $past(rd_req_o));

  p_req_single_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o |=> !rd_req_o);

  p_tar_after_req_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req_o && frame_ni) |=> (lad_oe_o && lad_o == 4'hF));

  p_wait_after_tar_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lad_oe_o && lad_o == 4'hF && $past(rd_req_o) && frame_ni) |=> (lad_oe_o && lad_o == 4'h5));

  p_float_ones_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lad_oe_o |-> (lad_o == 4'hF));

  p_abort_release_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_ni |=> (!lad_oe_o && !rd_req_o));
endmodule

bind lpc_rd_target lpc_rd_target_chk u_chk (.*);

// File: tb/lpc_rd_target_bench.sv
module lpc_rd_target_bench;
  localparam logic [2:0] DEV_ID = 3'b101;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        frame_n = 1'b1;
  logic [3:0]  lad_h = 4'hF;
  logic [7:0]  rd_data = 8'h00;
  logic [3:0]  lad_o;
  logic        lad_oe_o;
  logic        rd_req_o;
  logic [18:0] rd_addr_o;
  logic        rd_mem_o;

  int n_cmp = 0;
  int n_bad = 0;

  always #5 clk_i = ~clk_i;

  lpc_rd_target u_lpc_rd_target (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .frame_ni  (frame_n),
    .lad_i     (lad_h),
    .dev_id_i  (DEV_ID),
    .rd_data_i (rd_data),
    .lad_o     (lad_o),
    .lad_oe_o  (lad_oe_o),
    .rd_req_o  (rd_req_o),
    .rd_addr_o (rd_addr_o),
    .rd_mem_o  (rd_mem_o)
  );

  function automatic logic [7:0] model(input logic sp, input logic [18:0] la);
    return la[7:0] ^ {la[14:11], la[18:15]} ^ (sp ? 8'h5A : 8'h00);
  endfunction

  // one-clock-latency store, holds its output
  always_ff @(posedge clk_i)
    if (rd_req_o) rd_data <= model(rd_mem_o, rd_addr_o);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_nib(input int p, input logic [7:0] d);
    case (p)
      13, 14:  return 4'h5;
      15:      return 4'h0;
      16:      return d[3:0];
      17:      return d[7:4];
      default: return 4'hF;
    endcase
  endfunction

  task automatic do_read(input logic [3:0] st, input logic [3:0] ct,
                         input logic [31:0] a, input int abort_at);
    bit         exp;
    logic [7:0] d;
    string      tag;
    exp = (st == 4'h0) && (ct[3:2] == 2'b01) && !ct[1] &&
          (&a[31:23]) && (a[21:19] == DEV_ID);
    d   = model(a[22], a[18:0]);
    tag = (st != 4'h0) ? "R2 ignored start" :
          ((ct[3:2] != 2'b01) || ct[1]) ? "R3 ignored type" : "R5 ignored address";
    for (int p = 1; p <= 19; p++) begin
      @(negedge clk_i);
      if (p == abort_at) begin
        frame_n = 1'b0;
        lad_h   = 4'hF;
        @(negedge clk_i);
        frame_n = 1'b1;
        chk("R8 release after abort", {31'b0, lad_oe_o}, 32'd0);
        chk("R8 no request after abort", {31'b0, rd_req_o}, 32'd0);
        return;
      end
      frame_n = (p != 1);
      lad_h   = (p == 1) ? st :
                (p == 2) ? ct :
                (p >= 3 && p <= 10) ? a[(43 - 4*p) -: 4] : 4'hF;
      if (exp) begin
        chk("R6 request timing", {31'b0, rd_req_o}, {31'b0, p == 11});
        if (p == 11) begin
          chk("R4 store address", {13'b0, rd_addr_o}, {13'b0, a[18:0]});
          chk("R4 space select", {31'b0, rd_mem_o}, {31'b0, a[22]});
        end
        chk("R7 drive enable", {31'b0, lad_oe_o}, {31'b0, p >= 12 && p <= 18});
        if (p >= 16 && p <= 17)
          chk("R9 data nibble", {28'b0, lad_o}, {28'b0, exp_nib(p, d)});
        else
          chk("R7 nibble", {28'b0, lad_o}, {28'b0, exp_nib(p, d)});
      end else begin
        chk(tag, {31'b0, lad_oe_o}, 32'd0);
        chk(tag, {31'b0, rd_req_o}, 32'd0);
      end
    end
  endtask

  function automatic logic [31:0] good_addr(input int i);
    logic [18:0] lo;
    lo = 19'(i * 32'h1D3B7 + 32'h00A5);
    return {9'h1FF, i[0], DEV_ID, lo};
  endfunction

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    summary();
    $finish;
  end

  initial begin : main
    logic [31:0] a;
    repeat (3) @(negedge clk_i);
    chk("R1 reset oe", {31'b0, lad_oe_o}, 32'd0);
    chk("R1 reset nibble", {28'b0, lad_o}, 32'hF);
    chk("R1 reset req", {31'b0, rd_req_o}, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 after release oe", {31'b0, lad_oe_o}, 32'd0);
    chk("R1 after release nibble", {28'b0, lad_o}, 32'hF);

    // valid reads, both spaces, type bit 0 both values
    for (int i = 0; i < 32; i++)
      do_read(4'h0, i[1] ? 4'h5 : 4'h4, good_addr(i), 0);

    // every cycle-type code
    for (int c = 0; c < 16; c++)
      do_read(4'h0, 4'(c), good_addr(c + 40), 0);

    // every nonzero start code
    for (int s = 1; s < 16; s++)
      do_read(4'(s), 4'h4, good_addr(s + 60), 0);

    // each top address bit cleared
    for (int b = 23; b < 32; b++) begin
      a = good_addr(b);
      a[b] = 1'b0;
      do_read(4'h0, 4'h4, a, 0);
    end

    // every device ID
    for (int id = 0; id < 8; id++) begin
      a = good_addr(id + 80);
      a[21:19] = 3'(id);
      do_read(4'h0, 4'h4, a, 0);
    end

    // aborts in address, turnaround, sync and data phases
    do_read(4'h0, 4'h4, good_addr(91), 6);
    do_read(4'h0, 4'h4, good_addr(92), 12);
    do_read(4'h0, 4'h4, good_addr(93), 14);
    do_read(4'h0, 4'h4, good_addr(94), 16);
    do_read(4'h0, 4'h4, good_addr(95), 18);

    // R8 abort with immediate restart: partial cycle then a full one
    @(negedge clk_i); frame_n = 1'b0; lad_h = 4'h0;
    @(negedge clk_i); frame_n = 1'b1; lad_h = 4'h4;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk_i); lad_h = 4'hF;
    end
    do_read(4'h0, 4'h4, good_addr(97), 0);

    @(negedge clk_i);
    chk("R7 idle after cycles", {31'b0, lad_oe_o}, 32'd0);
    summary();
    $finish;
  end
endmodule